// File: doc/BRIEF.md
# Shared-Bus Flash and SRAM Access Controller

This block sits on the host side of a memory port where a NOR-style flash and an asynchronous SRAM share one address bus and one 16-bit data bus. They also share a single output-enable strobe and a single write-enable strobe. The host hands over one request at a time through a valid/ready handshake. Each request names the target device, carries an address and write data, states whether it is a read or a write, and gives per-byte enables. The controller turns the request into a timed bus cycle. It drives the chip enables, the strobes, the byte-lane controls and the data-bus driver enable. It then returns a one-cycle done pulse together with the read data.

Every bus timing minimum is given in nanoseconds and turned into a whole number of clock cycles from a clock-period parameter. Every access ends with a turnaround period in which neither device is selected. As a result, the two chip-select groups are never active together, and switching from one device to the other always leaves a clean gap. The byte-lane controls are used only for SRAM accesses. A flash access always moves the full 16-bit word.

Top module: `memc_shared_bus`

## Requirements
- R1: The flash is selected when `flash_ce_n` is 0. The SRAM is selected when `sram_ce1_n` is 0 and `sram_ce2` is 1. The two are never selected in the same clock cycle.
- R2: Whenever either device stops being selected, at least one whole clock cycle (and at least 3 ns) passes with neither device selected before any device is selected again.
- R3: `sram_lane_n[i]` goes low only during an SRAM access whose `req_be[i]` is 1. Bit 0 gates data bits 7..0 and bit 1 gates bits 15..8. During a flash access all lanes stay high, and a flash write stores all 16 bits whatever `req_be` holds.
- R4: A flash read keeps the flash enable low for at least 70 ns and `oe_n` low for at least 20 ns before the data is sampled, and returns the whole word. With the default 8 ns clock, `rsp_done` is high in the 10th cycle after the accepting edge.
- R5: An SRAM read keeps the SRAM selected for at least 70 ns and `oe_n` low for at least 35 ns before sampling. Bytes whose `req_be` bit is 0 read back as 0. `rsp_done` arrives in the 10th cycle after acceptance.
- R6: An SRAM write holds `we_n` low for at least 55 ns, drives the write data for at least 30 ns before `we_n` rises, and keeps the device selected for at least 70 ns. `rsp_done` arrives in the 10th cycle after acceptance.
- R7: A flash write keeps `mem_addr` stable while `we_n` is low, because the address is taken when `we_n` falls. It holds `we_n` low for at least 50 ns, keeps the flash selected with `we_n` high for at least 30 ns after `we_n` rises, and keeps the flash selected for at least 80 ns in total. `rsp_done` arrives in the 13th cycle after acceptance.
- R8: `dq_oe` is 1 only during write accesses and is never 1 while `oe_n` is 0.
- R9: `req_ready` is 1 only while the controller is idle and drops in the cycle after a request is accepted. Each request yields exactly one single-cycle `rsp_done` pulse, in request order. `req_tgt` is 0 for flash and 1 for SRAM, and `req_we` is 1 for a write.
- R10: After reset, both devices are deselected, `oe_n`, `we_n` and all lanes are high, `dq_oe` and `rsp_done` are 0, and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, period CLK_NS |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken on valid and ready |
| req_tgt | input | 1 | Target: 0 flash, 1 SRAM |
| req_we | input | 1 | 1 write, 0 read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| req_be | input | DW/8 | Byte enables, bit 0 for bits 7..0 |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Read data of the last completed read |
| mem_addr | output | AW | Shared address bus |
| dq_out | output | DW | Data toward the memories |
| dq_oe | output | 1 | Data bus driver enable |
| dq_in | input | DW | Data from the memories |
| flash_ce_n | output | 1 | Flash chip enable, active low |
| sram_ce1_n | output | 1 | SRAM enable, active low |
| sram_ce2 | output | 1 | SRAM enable, active high |
| oe_n | output | 1 | Shared output enable, active low |
| we_n | output | 1 | Shared write enable, active low |
| sram_lane_n | output | DW/8 | SRAM byte-lane controls, active low |

## Verification
The done pulse is due a fixed number of cycles after the accepting edge. It is due in cycle 10 for reads and SRAM writes and in cycle 13 for flash writes. The bench counts falling edges from acceptance and compares that count with these values. The bench's memory model checks the pins at every falling edge, halfway between the edges where the controller changes them. It returns valid read data only once the enable and output-enable times have actually elapsed, so a sample taken one cycle early reads a poison value. Write pulse widths, data lead time, recovery time and the deselect gap are measured in whole cycles at the moment each strobe or enable changes.

// File: rtl/memc_pkg.sv
`timescale 1ns/1ps
// memc_pkg: shared phase/target types, device timing minima in ns, and the
// integer helpers used to turn them into cycle counts.
package memc_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_RECOVER,
        PH_GAP
    } phase_t;

    typedef enum logic {
        TGT_FLASH = 1'b0,
        TGT_SRAM  = 1'b1
    } tgt_t;

    // flash minima (ns)
    localparam int FL_ACC_NS  = 70;
    localparam int FL_OE_NS   = 20;
    localparam int FL_WC_NS   = 80;
    localparam int FL_WP_NS   = 50;
    localparam int FL_WPH_NS  = 30;
    localparam int FL_AH_NS   = 45;
    // sram minima (ns)
    localparam int SR_RC_NS   = 70;
    localparam int SR_OE_NS   = 35;
    localparam int SR_WC_NS   = 70;
    localparam int SR_WP_NS   = 55;
    localparam int SR_DS_NS   = 30;
    // deselect-to-select separation between the devices (ns)
    localparam int XFER_HOLD_NS = 3;

    function automatic int cdiv(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/memc_seq.sv
`timescale 1ns/1ps
// memc_seq: request latch and access phase sequencer.
// Walks IDLE -> SETUP -> STROBE -> (RECOVER for writes) -> GAP -> IDLE.
// Assumes all *_CYC parameters are at least 1; counts are loaded as N-1.
module memc_seq #(
    parameter int AW       = 22,
    parameter int DW       = 16,
    parameter int CNT_W    = 4,
    parameter int RD_F_CYC = 8,
    parameter int RD_S_CYC = 8,
    parameter int WP_F_CYC = 7,
    parameter int WP_S_CYC = 7,
    parameter int RC_F_CYC = 4,
    parameter int RC_S_CYC = 1,
    parameter int GAP_CYC  = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_tgt,
    input  logic                    req_we,
    input  logic [AW-1:0]           req_addr,
    input  logic [DW-1:0]           req_wdata,
    input  logic [DW/8-1:0]         req_be,
    output memc_pkg::phase_t        phase,
    output memc_pkg::tgt_t          cur_tgt,
    output logic                    cur_we,
    output logic [AW-1:0]           cur_addr,
    output logic [DW-1:0]           cur_wdata,
    output logic [DW/8-1:0]         cur_be,
    output logic                    capture,
    output logic                    done
);
    import memc_pkg::*;

    localparam logic [CNT_W-1:0] C_RD_F = CNT_W'(RD_F_CYC - 1);
    localparam logic [CNT_W-1:0] C_RD_S = CNT_W'(RD_S_CYC - 1);
    localparam logic [CNT_W-1:0] C_WP_F = CNT_W'(WP_F_CYC - 1);
    localparam logic [CNT_W-1:0] C_WP_S = CNT_W'(WP_S_CYC - 1);
    localparam logic [CNT_W-1:0] C_RC_F = CNT_W'(RC_F_CYC - 1);
    localparam logic [CNT_W-1:0] C_RC_S = CNT_W'(RC_S_CYC - 1);
    localparam logic [CNT_W-1:0] C_GAP  = CNT_W'(GAP_CYC - 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] strobe_len;
    logic [CNT_W-1:0] rec_len;
    logic             is_flash;

    assign is_flash  = (cur_tgt == TGT_FLASH);
    assign req_ready = (phase == PH_IDLE);
    assign capture   = (phase == PH_STROBE) && (cnt == '0) && !cur_we;

    // Pick the strobe and recovery lengths for the latched request.
    always_comb begin
        if (cur_we) strobe_len = is_flash ? C_WP_F : C_WP_S;
        else        strobe_len = is_flash ? C_RD_F : C_RD_S;
        rec_len = is_flash ? C_RC_F : C_RC_S;
    end

    // Phase register, cycle counter, request latch and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            done      <= 1'b0;
            cur_tgt   <= TGT_FLASH;
            cur_we    <= 1'b0;
            cur_addr  <= '0;
            cur_wdata <= '0;
            cur_be    <= '0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (req_valid) begin
                        cur_tgt   <= tgt_t'(req_tgt);
                        cur_we    <= req_we;
                        cur_addr  <= req_addr;
                        cur_wdata <= req_wdata;
                        cur_be    <= req_be;
                        phase     <= PH_SETUP;
                    end
                end
                PH_SETUP: begin
                    phase <= PH_STROBE;
                    cnt   <= strobe_len;
                end
                PH_STROBE: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else if (cur_we) begin
                        phase <= PH_RECOVER;
                        cnt   <= rec_len;
                    end else begin
                        phase <= PH_GAP;
                        cnt   <= C_GAP;
                        done  <= 1'b1;
                    end
                end
                PH_RECOVER: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        phase <= PH_GAP;
                        cnt   <= C_GAP;
                        done  <= 1'b1;
                    end
                end
                PH_GAP: begin
                    if (cnt != '0) cnt <= cnt - 1'b1;
                    else           phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/memc_pins.sv
`timescale 1ns/1ps
// memc_pins: decodes the sequencer phase into bus pins and captures read data.
// Assumes DW is a multiple of 8; lane g covers data bits 8g+7..8g.
// Only SRAM accesses honour the byte enables; flash always uses every lane.
module memc_pins #(
    parameter int AW = 22,
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  memc_pkg::phase_t     phase,
    input  memc_pkg::tgt_t       cur_tgt,
    input  logic                 cur_we,
    input  logic [AW-1:0]        cur_addr,
    input  logic [DW-1:0]        cur_wdata,
    input  logic [DW/8-1:0]      cur_be,
    input  logic                 capture,
    input  logic [DW-1:0]        dq_in,
    output logic [AW-1:0]        mem_addr,
    output logic [DW-1:0]        dq_out,
    output logic                 dq_oe,
    output logic                 flash_ce_n,
    output logic                 sram_ce1_n,
    output logic                 sram_ce2,
    output logic                 oe_n,
    output logic                 we_n,
    output logic [DW/8-1:0]      sram_lane_n,
    output logic [DW-1:0]        rsp_rdata
);
    import memc_pkg::*;

    localparam int LANES = DW / 8;

    logic active;
    logic fl_sel;
    logic sr_sel;
    logic strobe;

    assign active     = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_RECOVER);
    assign strobe     = (phase == PH_STROBE);
    assign fl_sel     = active && (cur_tgt == TGT_FLASH);
    assign sr_sel     = active && (cur_tgt == TGT_SRAM);

    assign flash_ce_n = !fl_sel;
    assign sram_ce1_n = !sr_sel;
    assign sram_ce2   = sr_sel;
    assign oe_n       = !(strobe && !cur_we);
    assign we_n       = !(strobe && cur_we);
    assign dq_oe      = active && cur_we;
    assign mem_addr   = cur_addr;
    assign dq_out     = cur_wdata;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign sram_lane_n[g] = !(sr_sel && cur_be[g]);
    end

    // Capture read data at the end of the strobe, zeroing disabled SRAM lanes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
        end else if (capture) begin
            for (int i = 0; i < LANES; i++) begin
                rsp_rdata[i*8 +: 8] <= (cur_tgt == TGT_FLASH || cur_be[i]) ? dq_in[i*8 +: 8] : 8'h00;
            end
        end
    end

endmodule

// File: rtl/memc_shared_bus.sv
`timescale 1ns/1ps
// memc_shared_bus: one-at-a-time access controller for a flash and an SRAM
// sharing address, data, OE and WE. Timing minima are converted to cycles
// from CLK_NS. Assumes a synchronous active-low reset and DW a multiple of 8.
module memc_shared_bus #(
    parameter int CLK_NS = 8,
    parameter int AW     = 22,
    parameter int DW     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_tgt,
    input  logic              req_we,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    input  logic [DW/8-1:0]   req_be,
    output logic              rsp_done,
    output logic [DW-1:0]     rsp_rdata,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     dq_out,
    output logic              dq_oe,
    input  logic [DW-1:0]     dq_in,
    output logic              flash_ce_n,
    output logic              sram_ce1_n,
    output logic              sram_ce2,
    output logic              oe_n,
    output logic              we_n,
    output logic [DW/8-1:0]   sram_lane_n
);
    import memc_pkg::*;

    localparam int LANES    = DW / 8;
    // read strobe: OE time, and enable time minus the setup cycle
    localparam int RD_F_CYC = imax(cdiv(FL_OE_NS, CLK_NS), cdiv(FL_ACC_NS, CLK_NS) - 1);
    localparam int RD_S_CYC = imax(cdiv(SR_OE_NS, CLK_NS), cdiv(SR_RC_NS, CLK_NS) - 1);
    // write pulse: WE width, address hold (flash), data lead minus setup cycle (sram)
    localparam int WP_F_CYC = imax(cdiv(FL_WP_NS, CLK_NS), cdiv(FL_AH_NS, CLK_NS));
    localparam int WP_S_CYC = imax(cdiv(SR_WP_NS, CLK_NS), cdiv(SR_DS_NS, CLK_NS) - 1);
    // recovery after WE rises, padding the whole cycle to its minimum
    localparam int RC_F_CYC = imax(cdiv(FL_WPH_NS, CLK_NS), cdiv(FL_WC_NS, CLK_NS) - 1 - WP_F_CYC);
    localparam int RC_S_CYC = imax(1, cdiv(SR_WC_NS, CLK_NS) - 1 - WP_S_CYC);
    localparam int GAP_CYC  = imax(1, cdiv(XFER_HOLD_NS, CLK_NS));
    localparam int MAXC     = imax(imax(imax(RD_F_CYC, RD_S_CYC), imax(WP_F_CYC, WP_S_CYC)),
                                   imax(imax(RC_F_CYC, RC_S_CYC), GAP_CYC));
    localparam int CNT_W    = $clog2(MAXC + 1);

    phase_t             phase;
    tgt_t               cur_tgt;
    logic               cur_we;
    logic [AW-1:0]      cur_addr;
    logic [DW-1:0]      cur_wdata;
    logic [LANES-1:0]   cur_be;
    logic               capture;

    memc_seq #(
        .AW(AW), .DW(DW), .CNT_W(CNT_W),
        .RD_F_CYC(RD_F_CYC), .RD_S_CYC(RD_S_CYC),
        .WP_F_CYC(WP_F_CYC), .WP_S_CYC(WP_S_CYC),
        .RC_F_CYC(RC_F_CYC), .RC_S_CYC(RC_S_CYC),
        .GAP_CYC(GAP_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_tgt   (req_tgt),
        .req_we    (req_we),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_be    (req_be),
        .phase     (phase),
        .cur_tgt   (cur_tgt),
        .cur_we    (cur_we),
        .cur_addr  (cur_addr),
        .cur_wdata (cur_wdata),
        .cur_be    (cur_be),
        .capture   (capture),
        .done      (rsp_done)
    );

    memc_pins #(.AW(AW), .DW(DW)) u_pins (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase       (phase),
        .cur_tgt     (cur_tgt),
        .cur_we      (cur_we),
        .cur_addr    (cur_addr),
        .cur_wdata   (cur_wdata),
        .cur_be      (cur_be),
        .capture     (capture),
        .dq_in       (dq_in),
        .mem_addr    (mem_addr),
        .dq_out      (dq_out),
        .dq_oe       (dq_oe),
        .flash_ce_n  (flash_ce_n),
        .sram_ce1_n  (sram_ce1_n),
        .sram_ce2    (sram_ce2),
        .oe_n        (oe_n),
        .we_n        (we_n),
        .sram_lane_n (sram_lane_n),
        .rsp_rdata   (rsp_rdata)
    );

endmodule

// File: rtl/memc_checker.sv
`timescale 1ns/1ps
// memc_checker: protocol properties on the pins of memc_shared_bus.
// Assumes synchronous active-low reset; the WE width is tracked by a counter.
module memc_checker #(
    parameter int CLK_NS = 8,
    parameter int AW     = 22,
    parameter int LANES  = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_done,
    input logic [AW-1:0]    mem_addr,
    input logic             dq_oe,
    input logic             flash_ce_n,
    input logic             sram_ce1_n,
    input logic             sram_ce2,
    input logic             oe_n,
    input logic             we_n,
    input logic [LANES-1:0] sram_lane_n
);
    localparam int WE_MIN_CYC = memc_pkg::cdiv(memc_pkg::FL_WP_NS, CLK_NS);

    logic       sr_on;
    logic [15:0] we_lo;

    assign sr_on = !sram_ce1_n && sram_ce2;

    // Count consecutive cycles with WE low.
    always_ff @(posedge clk) begin
        if (!rst_n)     we_lo <= '0;
        else if (!we_n) we_lo <= we_lo + 16'd1;
        else            we_lo <= '0;
    end

    a_r1_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!flash_ce_n && sr_on));

    a_r2_gap_after_flash: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_ce_n) |-> !sr_on);

    a_r2_gap_after_sram: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sr_on) |-> flash_ce_n);

    a_r3_flash_lanes_off: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_ce_n |-> (sram_lane_n == {LANES{1'b1}}));

    a_r6_data_before_we: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |-> $past(dq_oe));

    a_r6_we_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (int'(we_lo) >= WE_MIN_CYC));

    a_r7_addr_stable_we: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> $stable(mem_addr));

    a_r8_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> !dq_oe);

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r9_done_not_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> !req_ready);

endmodule

bind memc_shared_bus memc_checker #(.CLK_NS(CLK_NS), .AW(AW), .LANES(LANES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .rsp_done    (rsp_done),
    .mem_addr    (mem_addr),
    .dq_oe       (dq_oe),
    .flash_ce_n  (flash_ce_n),
    .sram_ce1_n  (sram_ce1_n),
    .sram_ce2    (sram_ce2),
    .oe_n        (oe_n),
    .we_n        (we_n),
    .sram_lane_n (sram_lane_n)
);

// File: tb/tb_memc_shared_bus.sv
`timescale 1ns/1ps
// tb_memc_shared_bus: bus-level model of both memories plus directed and
// seeded random requests; all pin checks happen on the falling clock edge.
module tb_memc_shared_bus;

    localparam int CLK = 8;
    localparam int LAT_READ = 10;
    localparam int LAT_SWR  = 10;
    localparam int LAT_FWR  = 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_tgt = 1'b0;
    logic        req_we = 1'b0;
    logic [21:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        rsp_done;
    logic [15:0] rsp_rdata;
    logic [21:0] mem_addr;
    logic [15:0] dq_out;
    logic        dq_oe;
    logic [15:0] dq_in = 16'hBAD0;
    logic        flash_ce_n, sram_ce1_n, sram_ce2, oe_n, we_n;
    logic [1:0]  sram_lane_n;

    int checks = 0;
    int errors = 0;

    always #(CLK/2) clk = ~clk;

    memc_shared_bus dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_tgt(req_tgt), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in),
        .flash_ce_n(flash_ce_n), .sram_ce1_n(sram_ce1_n), .sram_ce2(sram_ce2),
        .oe_n(oe_n), .we_n(we_n), .sram_lane_n(sram_lane_n)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] init_val(input bit t, input logic [21:0] a);
        return a[15:0] ^ (t ? 16'h3C3C : 16'hA5A5);
    endfunction

    // model memories (written through the pins) and expected shadows
    logic [15:0] mf [logic [21:0]];
    logic [15:0] ms [logic [21:0]];
    logic [15:0] ef [logic [21:0]];
    logic [15:0] es [logic [21:0]];

    function automatic logic [15:0] mget(input bit t, input logic [21:0] a);
        if (t) return ms.exists({3'b0, a[18:0]}) ? ms[{3'b0, a[18:0]}] : init_val(1'b1, {3'b0, a[18:0]});
        return mf.exists(a) ? mf[a] : init_val(1'b0, a);
    endfunction

    function automatic logic [15:0] eget(input bit t, input logic [21:0] a);
        if (t) return es.exists({3'b0, a[18:0]}) ? es[{3'b0, a[18:0]}] : init_val(1'b1, {3'b0, a[18:0]});
        return ef.exists(a) ? ef[a] : init_val(1'b0, a);
    endfunction

    // bus model state
    bit          f_prev, s_prev, we_prev, wrote;
    int          ce_cnt, oe_cnt, we_cnt, drv_cnt, hi_cnt;
    logic [21:0] fl_addr;
    logic [15:0] last_dq;
    logic [1:0]  seen_lanes;

    // Memory model and pin monitor, evaluated mid-cycle.
    always @(negedge clk) begin
        bit fsel, ssel;
        logic [15:0] v;
        if (!rst_n) begin
            f_prev = 0; s_prev = 0; we_prev = 1; wrote = 0;
            ce_cnt = 0; oe_cnt = 0; we_cnt = 0; drv_cnt = 0; hi_cnt = 0;
            dq_in = 16'hBAD0;
        end else begin
            fsel = !flash_ce_n;
            ssel = !sram_ce1_n && sram_ce2;
            if (fsel && ssel) chk(0, "R1 both selected", 32'd1, 32'd0);
            if ((fsel && s_prev) || (ssel && f_prev)) chk(0, "R2 no gap between devices", 32'd0, 32'd1);
            if (fsel && sram_lane_n != 2'b11) chk(0, "R3 lanes during flash", 32'(sram_lane_n), 32'h3);
            if (ssel) seen_lanes = sram_lane_n;
            if (dq_oe && !oe_n) chk(0, "R8 bus driven during read", 32'd1, 32'd0);
            // WE rising: width and data lead
            if (we_n && !we_prev) begin
                chk(we_cnt * CLK >= (f_prev ? 50 : 55), f_prev ? "R7 WE low width" : "R6 WE low width",
                    32'(we_cnt * CLK), f_prev ? 32'd50 : 32'd55);
                chk(drv_cnt * CLK >= 30, "R6 data lead before WE rise", 32'(drv_cnt * CLK), 32'd30);
                if (f_prev) mf[fl_addr] = last_dq;
                hi_cnt = 0;
                wrote = 1;
            end
            if (!we_n && ssel) begin
                v = mget(1'b1, mem_addr);
                if (!sram_lane_n[0]) v[7:0]  = dq_out[7:0];
                if (!sram_lane_n[1]) v[15:8] = dq_out[15:8];
                ms[{3'b0, mem_addr[18:0]}] = v;
            end
            if (!we_n && we_prev && fsel) fl_addr = mem_addr;
            if (!we_n && !we_prev && fsel && mem_addr != fl_addr) chk(0, "R7 address moved under WE", 32'(mem_addr), 32'(fl_addr));
            if (!we_n) last_dq = dq_out;
            // deselect: total enable time and flash recovery
            if ((f_prev && !fsel) || (s_prev && !ssel)) begin
                chk(ce_cnt * CLK >= ((f_prev && wrote) ? 80 : 70), "R4 R5 R6 R7 enable duration",
                    32'(ce_cnt * CLK), (f_prev && wrote) ? 32'd80 : 32'd70);
                if (f_prev && wrote) chk(hi_cnt * CLK >= 30, "R7 WE high before deselect", 32'(hi_cnt * CLK), 32'd30);
                wrote = 0;
            end
            ce_cnt  = (fsel || ssel) ? ce_cnt + 1 : 0;
            oe_cnt  = (!oe_n) ? oe_cnt + 1 : 0;
            we_cnt  = (!we_n) ? we_cnt + 1 : 0;
            drv_cnt = dq_oe ? drv_cnt + 1 : 0;
            if (fsel && we_n && wrote) hi_cnt = hi_cnt + 1;
            // read data appears only once access times have elapsed
            dq_in = 16'hBAD0;
            if (!oe_n && fsel && ce_cnt * CLK >= 70 && oe_cnt * CLK >= 20) begin
                dq_in = mget(1'b0, mem_addr);
            end else if (!oe_n && ssel && ce_cnt * CLK >= 70 && oe_cnt * CLK >= 35) begin
                v = mget(1'b1, mem_addr);
                dq_in[7:0]  = sram_lane_n[0] ? 8'hEE : v[7:0];
                dq_in[15:8] = sram_lane_n[1] ? 8'hEE : v[15:8];
            end
            f_prev = fsel; s_prev = ssel; we_prev = we_n;
        end
    end

    // Issue one request and check latency, handshake, lanes and read data.
    task automatic do_req(input bit t, input bit w, input logic [21:0] a, input logic [15:0] d, input logic [1:0] be);
        int n;
        int lat;
        logic [15:0] exp, cur;
        @(negedge clk);
        req_tgt = t; req_we = w; req_addr = a; req_wdata = d; req_be = be; req_valid = 1'b1;
        seen_lanes = 2'b11;
        do @(posedge clk); while (!req_ready);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R9 ready drops after accept", 32'(req_ready), 32'd0);
        n = 1;
        while (!rsp_done && n < 100) begin
            @(negedge clk);
            n++;
        end
        lat = w ? (t ? LAT_SWR : LAT_FWR) : LAT_READ;
        chk(n == lat, t ? (w ? "R6 done latency" : "R5 done latency") : (w ? "R7 done latency" : "R4 done latency"),
            32'(n), 32'(lat));
        chk(seen_lanes == (t ? ~be : 2'b11), "R3 lane controls", 32'(seen_lanes), t ? 32'(~be) : 32'h3);
        if (w) begin
            if (t) begin
                cur = eget(1'b1, a);
                if (be[0]) cur[7:0]  = d[7:0];
                if (be[1]) cur[15:8] = d[15:8];
                es[{3'b0, a[18:0]}] = cur;
            end else begin
                ef[a] = d;
            end
        end else begin
            exp = eget(t, a);
            if (t) begin
                if (!be[0]) exp[7:0]  = 8'h00;
                if (!be[1]) exp[15:8] = 8'h00;
            end
            chk(rsp_rdata == exp, t ? "R5 sram read data" : "R4 flash read data", 32'(rsp_rdata), 32'(exp));
        end
        @(negedge clk);
        chk(!rsp_done, "R9 done is one cycle", 32'(rsp_done), 32'd0);
    endtask

    logic [21:0] pool [8];

    initial begin
        int seed;
        seed = $urandom(32'h00C0FFEE);
        for (int i = 0; i < 8; i++) pool[i] = 22'($urandom());
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(req_ready == 1'b1, "R10 ready after reset", 32'(req_ready), 32'd1);
        chk({flash_ce_n, sram_ce1_n, sram_ce2} == 3'b110, "R10 devices deselected",
            32'({flash_ce_n, sram_ce1_n, sram_ce2}), 32'h6);
        chk({oe_n, we_n, sram_lane_n} == 4'hF, "R10 strobes and lanes high", 32'({oe_n, we_n, sram_lane_n}), 32'hF);
        chk({dq_oe, rsp_done} == 2'b00, "R10 no drive no done", 32'({dq_oe, rsp_done}), 32'd0);

        // directed: SRAM full and partial writes, lane-masked reads (R3 R5 R6)
        do_req(1'b1, 1'b1, pool[0], 16'h1234, 2'b11);
        do_req(1'b1, 1'b0, pool[0], 16'h0000, 2'b11);
        do_req(1'b1, 1'b1, pool[0], 16'hABCD, 2'b01);
        do_req(1'b1, 1'b0, pool[0], 16'h0000, 2'b11);
        do_req(1'b1, 1'b0, pool[0], 16'h0000, 2'b10);
        do_req(1'b1, 1'b0, pool[0], 16'h0000, 2'b00);
        do_req(1'b1, 1'b1, pool[3], 16'h5AA5, 2'b10);
        do_req(1'b1, 1'b0, pool[3], 16'h0000, 2'b11);
        // directed: flash write ignores byte enables (R3 R7), untouched read (R4)
        do_req(1'b0, 1'b1, pool[1], 16'hC3E1, 2'b00);
        do_req(1'b0, 1'b0, pool[1], 16'h0000, 2'b00);
        do_req(1'b0, 1'b0, pool[2], 16'h0000, 2'b11);
        // directed: alternate devices back to back (R1 R2)
        do_req(1'b0, 1'b0, pool[1], 16'h0000, 2'b11);
        do_req(1'b1, 1'b0, pool[0], 16'h0000, 2'b11);
        do_req(1'b0, 1'b1, pool[4], 16'h0F0F, 2'b11);
        do_req(1'b1, 1'b1, pool[4], 16'hF00F, 2'b11);
        do_req(1'b0, 1'b0, pool[4], 16'h0000, 2'b01);

        // seeded random mix over a small address pool
        for (int i = 0; i < 80; i++) begin
            do_req(1'($urandom()), 1'($urandom()), pool[$urandom() % 8], 16'($urandom()), 2'($urandom()));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is reported as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R9 watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule